// File: doc/BRIEF.md
# Serial GPIO Input Interrupt Unit

This unit turns the sampled inputs of a serial GPIO chain into one interrupt line. A serial controller shifts the chain in and hands over a parallel vector of all inputs together with a one-cycle burst-done strobe. The vector is arranged as up to 32 ports times up to 4 bit indices. Each input has its own trigger type: level (high or low), rising edge, falling edge or both edges. The unit keeps a pending flag per input. For each bit index it provides an enable mask, an acknowledge register and an identification register. A single interrupt output combines everything behind a master enable.

Software programs the unit through a simple register port: a one-cycle write strobe with an address and write data, and a read data output that is combinational from the address. Edge events are formed only when a burst completes, by comparing the new sample with the sample of the previous burst. Level sources follow the most recent burst sample through their polarity. The number of ports must not exceed the 32-bit register width.

Top module: `sgii_irq_unit`

## Requirements
- R1: After reset every register reads zero, no input is pending, the identification registers read zero and irq_o is low.
- R2: The trigger type of the input at port p, bit index b is a 2-bit code. Its low bit is bit p of the register at address 0x08+b, and its high bit is bit p of the register at address 0x0C+b. Code 0 selects level, 1 selects both edges, 2 selects falling edge and 3 selects rising edge.
- R3: Edge events are evaluated only in a cycle with burst_done_i high, against the sample stored at the previous burst. The first burst after reset never produces an edge event. Changes on sample_i without the strobe have no effect.
- R4: A rising (0 to 1), falling (1 to 0) or either transition between consecutive bursts sets the pending flag of an input whose type is rising, falling or both edges, respectively. The flag stays set until it is acknowledged.
- R5: For a level-type input the pending flag equals the last burst sample XOR bit p of the polarity register at 0x10+b, where 0 means active high and 1 means active low. It is low until the first burst. An acknowledge does not clear it while the level persists.
- R6: The enable register at 0x14+b masks the inputs of bit index b. The identification register at 0x1C+b reads the inputs that are both pending and enabled, with bit p standing for port p.
- R7: Writing the register at 0x18+b clears the edge pending flag of every port whose data bit is 1. Ports whose data bit is 0 keep their flag. An edge event arriving in the same cycle as its acknowledge is kept.
- R8: irq_o is high exactly when bit 0 of the configuration register at 0x00 (the master enable) is set and at least one identification bit of any bit index is set.
- R9: The configuration, trigger, polarity and enable registers read back the values written to them. The acknowledge registers read zero. Writes to the identification registers are ignored.
- R10: sample_i carries the input of port p, bit index b at position b*NUM_PORTS+p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sample_i | input | NUM_BITS*NUM_PORTS | Parallel sampled inputs from the serial controller |
| burst_done_i | input | 1 | One-cycle strobe: sample_i holds a completed burst |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address (word index) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The pending state, the stored previous sample and the primed flag are all internal. A fault in any of them shows up in the identification read data and on irq_o. For edge and acknowledge state this happens in the cycle after the strobe or write that touched them. For level sources it happens as soon as the polarity register or the next burst changes the level. A wrong stored sample stays hidden until the following burst, where it appears as a spurious or missing edge. The bench therefore reads every identification register and irq_o after each burst and after each write, so every fault is caught within one burst of its cause.

// File: rtl/sgii_pkg.sv
package sgii_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 5;
    localparam int MAX_BITS = 4;

    localparam logic [ADDR_W-1:0] A_CFG   = 5'h00;
    localparam logic [ADDR_W-1:0] A_TRGLO = 5'h08;
    localparam logic [ADDR_W-1:0] A_TRGHI = 5'h0C;
    localparam logic [ADDR_W-1:0] A_POL   = 5'h10;
    localparam logic [ADDR_W-1:0] A_ENA   = 5'h14;
    localparam logic [ADDR_W-1:0] A_ACK   = 5'h18;
    localparam logic [ADDR_W-1:0] A_IDENT = 5'h1C;
endpackage

// File: rtl/sgii_cfg_regs.sv
module sgii_cfg_regs
    import sgii_pkg::*;
#(
    parameter int NP = 32,
    parameter int NB = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [REG_W-1:0]     wdata_i,
    input  logic [NB*NP-1:0]     ident_i,
    output logic                 master_o,
    output logic [NB*NP-1:0]     lo_o,
    output logic [NB*NP-1:0]     hi_o,
    output logic [NB*NP-1:0]     pol_o,
    output logic [NB*NP-1:0]     ena_o,
    output logic [NB*NP-1:0]     ack_o,
    output logic [REG_W-1:0]     rdata_o
);
    typedef struct packed {
        logic                   master;
        logic [NB-1:0][NP-1:0]  lo;
        logic [NB-1:0][NP-1:0]  hi;
        logic [NB-1:0][NP-1:0]  pol;
        logic [NB-1:0][NP-1:0]  ena;
    } cfg_t;

    cfg_t r_d, r_q;
    logic [NB-1:0][NP-1:0] ack_v;
    logic [NB-1:0][NP-1:0] ident_v;

    assign ident_v = ident_i;

    always_comb begin
        r_d   = r_q;
        ack_v = '0;
        if (wr_i) begin
            if (addr_i == A_CFG) r_d.master = wdata_i[0];
            for (int b = 0; b < NB; b++) begin
                if (addr_i == A_TRGLO + ADDR_W'(b)) r_d.lo[b]  = wdata_i[NP-1:0];
                if (addr_i == A_TRGHI + ADDR_W'(b)) r_d.hi[b]  = wdata_i[NP-1:0];
                if (addr_i == A_POL   + ADDR_W'(b)) r_d.pol[b] = wdata_i[NP-1:0];
                if (addr_i == A_ENA   + ADDR_W'(b)) r_d.ena[b] = wdata_i[NP-1:0];
                if (addr_i == A_ACK   + ADDR_W'(b)) ack_v[b]   = wdata_i[NP-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CFG) rdata_o = REG_W'(r_q.master);
        for (int b = 0; b < NB; b++) begin
            if (addr_i == A_TRGLO + ADDR_W'(b)) rdata_o = REG_W'(r_q.lo[b]);
            if (addr_i == A_TRGHI + ADDR_W'(b)) rdata_o = REG_W'(r_q.hi[b]);
            if (addr_i == A_POL   + ADDR_W'(b)) rdata_o = REG_W'(r_q.pol[b]);
            if (addr_i == A_ENA   + ADDR_W'(b)) rdata_o = REG_W'(r_q.ena[b]);
            if (addr_i == A_IDENT + ADDR_W'(b)) rdata_o = REG_W'(ident_v[b]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign master_o = r_q.master;
    assign lo_o     = r_q.lo;
    assign hi_o     = r_q.hi;
    assign pol_o    = r_q.pol;
    assign ena_o    = r_q.ena;
    assign ack_o    = ack_v;

    // master enable follows a write to the configuration register
    assert_master_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == A_CFG) |=> (master_o == $past(wdata_i[0])));
endmodule

// File: rtl/sgii_pin_detect.sv
module sgii_pin_detect #(
    parameter int NP = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          burst_i,
    input  logic [NP-1:0] smp_i,
    input  logic [NP-1:0] lo_i,
    input  logic [NP-1:0] hi_i,
    input  logic [NP-1:0] pol_i,
    input  logic [NP-1:0] ack_i,
    output logic [NP-1:0] pend_o
);
    typedef struct packed {
        logic          primed;
        logic [NP-1:0] smp;
        logic [NP-1:0] evt;
    } det_t;

    det_t r_d, r_q;
    logic [NP-1:0] rise, fall, is_lvl, hit;

    always_comb begin
        r_d    = r_q;
        rise   = smp_i & ~r_q.smp;
        fall   = ~smp_i & r_q.smp;
        is_lvl = ~lo_i & ~hi_i;
        hit    = (lo_i & ~hi_i & (rise | fall))
               | (~lo_i & hi_i & fall)
               | (lo_i & hi_i & rise);
        r_d.evt = r_q.evt & ~ack_i;
        if (burst_i) begin
            r_d.smp    = smp_i;
            r_d.primed = 1'b1;
            if (r_q.primed) r_d.evt = r_d.evt | hit;
        end
        pend_o = (is_lvl & (r_q.smp ^ pol_i) & {NP{r_q.primed}})
               | (~is_lvl & r_q.evt);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assert_sample_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_i |=> $stable(r_q.smp));

    assert_no_evt_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_i |=> ((r_q.evt & ~$past(r_q.evt)) == '0));

    assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!burst_i && ack_i != '0) |=> ((r_q.evt & $past(ack_i)) == '0));
endmodule

// File: rtl/sgii_irq_unit.sv
module sgii_irq_unit
    import sgii_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [NUM_BITS*NUM_PORTS-1:0] sample_i,
    input  logic                          burst_done_i,
    input  logic                          reg_wr_i,
    input  logic [4:0]                    reg_addr_i,
    input  logic [31:0]                   reg_wdata_i,
    output logic [31:0]                   reg_rdata_o,
    output logic                          irq_o
);
    localparam int NPIN = NUM_BITS * NUM_PORTS;

    logic            master;
    logic [NPIN-1:0] lo, hi, pol, ena, ack, pend, ident;

    sgii_cfg_regs #(.NP(NUM_PORTS), .NB(NUM_BITS)) cfg_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .ident_i  (ident),
        .master_o (master),
        .lo_o     (lo),
        .hi_o     (hi),
        .pol_o    (pol),
        .ena_o    (ena),
        .ack_o    (ack),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar b = 0; b < NUM_BITS; b++) begin : g_idx
        sgii_pin_detect #(.NP(NUM_PORTS)) det_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .burst_i (burst_done_i),
            .smp_i   (sample_i[b*NUM_PORTS +: NUM_PORTS]),
            .lo_i    (lo[b*NUM_PORTS +: NUM_PORTS]),
            .hi_i    (hi[b*NUM_PORTS +: NUM_PORTS]),
            .pol_i   (pol[b*NUM_PORTS +: NUM_PORTS]),
            .ack_i   (ack[b*NUM_PORTS +: NUM_PORTS]),
            .pend_o  (pend[b*NUM_PORTS +: NUM_PORTS])
        );
    end

    always_comb begin
        ident = pend & ena;
        irq_o = master & (|ident);
    end

    // an interrupt needs the master enable and some enabled input
    assert_irq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (master && (ena != '0)));
endmodule

// File: tb/sgii_irq_unit_tb.sv
module sgii_irq_unit_tb_top;
    localparam int NP = 8;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB*NP-1:0] sample = '0;
    logic          burst = 1'b0;
    logic          wr = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_lo[NB], m_hi[NB], m_pol[NB], m_en[NB], m_smp[NB], m_evt[NB];
    logic       m_primed, m_master;

    always #10 clk = ~clk;

    sgii_irq_unit #(.NUM_PORTS(NP), .NUM_BITS(NB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .burst_done_i(burst),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pend(input int b);
        logic [7:0] lvl;
        lvl = ~m_lo[b] & ~m_hi[b];
        return (lvl & (m_primed ? (m_smp[b] ^ m_pol[b]) : 8'h00)) | (~lvl & m_evt[b]);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_lo[b] = 0; m_hi[b] = 0; m_pol[b] = 0; m_en[b] = 0; m_smp[b] = 0; m_evt[b] = 0;
        end
        m_primed = 0; m_master = 0;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [31:0] d);
        if (a == 5'h00) m_master = d[0];
        for (int b = 0; b < NB; b++) begin
            if (a == 5'(8 + b))  m_lo[b]  = d[7:0];
            if (a == 5'(12 + b)) m_hi[b]  = d[7:0];
            if (a == 5'(16 + b)) m_pol[b] = d[7:0];
            if (a == 5'(20 + b)) m_en[b]  = d[7:0];
            if (a == 5'(24 + b)) m_evt[b] = m_evt[b] & ~d[7:0];
        end
    endtask

    task automatic model_burst(input logic [31:0] v);
        for (int b = 0; b < NB; b++) begin
            logic [7:0] nv, rs, fl, ev;
            nv = v[b*NP +: NP];
            rs = nv & ~m_smp[b];
            fl = ~nv & m_smp[b];
            ev = (m_lo[b] & ~m_hi[b] & (rs | fl)) | (~m_lo[b] & m_hi[b] & fl)
               | (m_lo[b] & m_hi[b] & rs);
            if (m_primed) m_evt[b] = m_evt[b] | ev;
            m_smp[b] = nv;
        end
        m_primed = 1'b1;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_burst(input logic [31:0] v);
        @(negedge clk);
        sample = v; burst = 1'b1;
        @(negedge clk);
        burst = 1'b0;
        model_burst(v);
    endtask

    task automatic do_burst_ack(input logic [31:0] v, input int b, input logic [7:0] m);
        @(negedge clk);
        sample = v; burst = 1'b1; wr = 1'b1; addr = 5'(24 + b); wdata = 32'(m);
        @(negedge clk);
        burst = 1'b0; wr = 1'b0;
        model_write(5'(24 + b), 32'(m));
        model_burst(v);
    endtask

    task automatic set_type_all(input int t);
        for (int b = 0; b < NB; b++) begin
            do_write(5'(8 + b),  t[0] ? 32'hFF : 32'h0);
            do_write(5'(12 + b), t[1] ? 32'hFF : 32'h0);
        end
    endtask

    task automatic check_all(input string req);
        logic any;
        any = 1'b0;
        for (int b = 0; b < NB; b++) begin
            logic [7:0] e;
            e = exp_pend(b) & m_en[b];
            any = any | (|e);
            addr = 5'(28 + b);
            #1;
            chk(req, rdata, 32'(e));
        end
        chk({req, " irq R8"}, 32'(irq), 32'(m_master & any));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every address
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a);
            #1;
            chk("R1 reset read", rdata, 32'h0);
        end
        chk("R1 reset irq", 32'(irq), 32'h0);

        // R9: readback, ack reads zero, ident write ignored
        do_write(5'h00, 32'hFFFF_FFFF);
        addr = 5'h00; #1; chk("R9 cfg", rdata, 32'h1);
        for (int b = 0; b < NB; b++) begin
            do_write(5'(8 + b),  32'(8'h11 * (b + 1)));
            do_write(5'(12 + b), 32'(8'h27 * (b + 3)));
            do_write(5'(16 + b), 32'(8'h5A ^ b));
            addr = 5'(8 + b);  #1; chk("R9 trig lo", rdata, 32'(8'h11 * (b + 1)));
            addr = 5'(12 + b); #1; chk("R9 trig hi", rdata, 32'(8'(8'h27 * (b + 3))));
            addr = 5'(16 + b); #1; chk("R9 pol", rdata, 32'(8'h5A ^ b));
            do_write(5'(24 + b), 32'hFF);
            addr = 5'(24 + b); #1; chk("R9 ack reads zero", rdata, 32'h0);
            do_write(5'(28 + b), 32'hFF);
            addr = 5'(28 + b); #1; chk("R9 ident write ignored", rdata, 32'h0);
        end

        // R5: level types do not pend before the first burst, even active low
        set_type_all(0);
        for (int b = 0; b < NB; b++) begin
            do_write(5'(16 + b), 32'hFF);
            do_write(5'(20 + b), 32'hFF);
        end
        check_all("R5 unprimed level");

        // R3: first burst produces no edge; sample without strobe is ignored
        set_type_all(3);
        do_burst(32'hFFFF_FFFF);
        check_all("R3 first burst");
        do_burst(32'h0000_0000);
        @(negedge clk); sample = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_all("R3 no strobe");

        // R2/R4/R5/R7: sweep each uniform type over many patterns
        for (int t = 0; t < 4; t++) begin
            set_type_all(t);
            for (int b = 0; b < NB; b++) do_write(5'(16 + b), 32'(8'h0F << b));
            for (int b = 0; b < NB; b++) do_write(5'(24 + b), 32'hFF);
            check_all("R2 type switch");
            for (int k = 0; k < 24; k++) begin
                logic [31:0] v;
                v = (32'h9E37_79B9 * (k + 7 * t + 1)) ^ (32'(k) << 5);
                do_burst(v);
                check_all(t == 0 ? "R5 level" : "R4 edge");
                if (k % 3 == 1) begin
                    do_write(5'(24 + (k % NB)), 32'(8'hC3 ^ k));
                    check_all("R7 partial ack");
                end
            end
        end

        // R2/R6/R10: mixed per-port types, polarities and enables
        for (int b = 0; b < NB; b++) begin
            do_write(5'(8 + b),  32'(8'hA5 ^ (b * 8'h11)));
            do_write(5'(12 + b), 32'(8'h3C ^ (b * 8'h21)));
            do_write(5'(16 + b), 32'(8'h96 >> b));
            do_write(5'(20 + b), 32'(8'hF7 ^ (8'h40 >> b)));
        end
        for (int k = 0; k < 40; k++) begin
            do_burst((32'h6C07_8965 * (k + 3)) ^ (32'h1 << (k % 32)));
            check_all("R10 mixed layout");
        end

        // R7: event in the same cycle as its acknowledge is kept
        set_type_all(3);
        for (int b = 0; b < NB; b++) do_write(5'(20 + b), 32'hFF);
        do_burst(32'h0);
        do_burst(32'h0000_00F0);
        do_burst_ack(32'h0000_00FF, 0, 8'hFF);
        check_all("R7 ack with event");

        // R5: ack leaves a held level pending
        set_type_all(0);
        for (int b = 0; b < NB; b++) do_write(5'(16 + b), 32'h00);
        do_write(5'h18, 32'hFF);
        check_all("R5 level after ack");

        // R8: master enable off and on
        do_write(5'h00, 32'h0);
        check_all("R8 master off");
        do_write(5'h00, 32'h1);
        check_all("R8 master on");

        // R6: all enables cleared
        for (int b = 0; b < NB; b++) do_write(5'(20 + b), 32'h0);
        check_all("R6 enables off");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule